// File: doc/BRIEF.md
# Accumulator ALU with Five-Flag Status

This block is the arithmetic and logic stage of a small accumulator-based processor. It combines the accumulator with a second byte, which is taken from a general register, a memory read or an immediate field. It returns an 8-bit result, a strobe telling the surrounding control whether to write that result into the accumulator, and a registered status byte holding sign, zero, half-carry, parity and carry.

The result and the write strobe are combinational. The status byte is a register. It loads the newly computed flags on a rising clock edge when the enclosing control raises the flag-load enable, and otherwise holds its value. The stored carry feeds the carry-in of add-with-carry and the borrow-in of subtract-with-borrow. Each operation decides which flags it may touch. Flags it leaves alone keep their stored value even when the load enable is high.

Top module: `alu8_flags`

## Requirements
- R1: The second operand is chosen by `src_sel_i`: 00 selects `reg_i`, 01 selects `mem_i`, and 10 or 11 selects `imm_i`.
- R2: `op_i` 0 (add) and 1 (add with carry) give `result_o` = low 8 bits of A + B (+ stored CY for op 1), and CY = carry out of bit 7.
- R3: `op_i` 2 (subtract), 3 (subtract with borrow, uses the stored CY) and 9 (compare) give `result_o` = A − B (− CY), with CY = 1 on a borrow. `acc_we_o` is 0 for compare and 1 for every other defined operation 0..12.
- R4: For every operation that updates them, S equals bit 7 of `result_o` and Z is 1 exactly when `result_o` is 00h.
- R5: AC is the carry out of bit 3 for add, add-with-carry and increment. It is the borrow into bit 3 for subtract, subtract-with-borrow, compare and decrement.
- R6: P is 1 when `result_o` has an even number of 1 bits, for every operation that updates it.
- R7: `op_i` 6, 7, 8 (AND, OR, XOR of A with B) clear both CY and AC and update S, Z and P.
- R8: `op_i` 4 and 5 increment and decrement A. They update S, Z, AC and P and leave CY at its stored value.
- R9: `op_i` 10 gives ~A and changes no flag. `op_i` 11 rotates A left circularly and `op_i` 12 rotates it right circularly. Both rotates copy the bit that wraps around into CY and change no other flag.
- R10: The status byte `flags_o` puts S at bit 7, Z at bit 6, AC at bit 4, P at bit 2 and CY at bit 0. Bits 5, 3 and 1 are always 0.
- R11: A synchronous high `rst` clears `flags_o` to 00h. While `flag_we_i` is 0, `flags_o` keeps its value across clock edges.
- R12: The unused codes 13 to 15 pass A to `result_o`, hold `acc_we_o` at 0 and change no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the status register loads on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the status byte |
| op_i | input | 4 | Operation code 0..15 |
| src_sel_i | input | 2 | Second-operand source select |
| acc_i | input | 8 | Accumulator operand |
| reg_i | input | 8 | General-register operand |
| mem_i | input | 8 | Memory-read operand |
| imm_i | input | 8 | Immediate operand |
| flag_we_i | input | 1 | Load enable for the status byte |
| result_o | output | 8 | Combinational result |
| acc_we_o | output | 1 | Accumulator write-back strobe |
| flags_o | output | 8 | Registered status byte |

## Verification
The bench aims at the places where an ALU tends to be slightly wrong. A sum that wraps to 00h must set both Z and CY, so a carry taken from the wrong bit shows up there. Subtract-with-borrow and add-with-carry are run with the stored carry both set and clear. A design that ignores the carry-in, or uses the inverted borrow convention, then gives results that are off by one. Half-carry is exercised on nibble boundaries in both directions (0Fh+1, 10h−1), which exposes a carry taken from bit 4 instead of bit 3.

Increment, complement and the rotates are issued with flags already set, to catch designs that clobber a flag they should preserve. Compare is checked for a result shown on the output while the write strobe stays low. Thousands of pseudo-random operations with random load enables then check the status byte packing and the hold behaviour against a behavioural model.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBB = 4'd3,
        OP_INC = 4'd4,
        OP_DEC = 4'd5,
        OP_AND = 4'd6,
        OP_OR  = 4'd7,
        OP_XOR = 4'd8,
        OP_CMP = 4'd9,
        OP_CPL = 4'd10,
        OP_RLC = 4'd11,
        OP_RRC = 4'd12
    } op_e;

    // Bit positions inside the status byte.
    localparam int FB_S  = 7;
    localparam int FB_Z  = 6;
    localparam int FB_AC = 4;
    localparam int FB_P  = 2;
    localparam int FB_CY = 0;
    localparam logic [7:0] FLAG_USED = 8'b1101_0101;

    typedef struct packed {
        logic s;
        logic z;
        logic ac;
        logic p;
        logic cy;
    } flag_set_t;

    localparam flag_set_t UPD_ALL   = flag_set_t'(5'b11111);
    localparam flag_set_t UPD_NO_CY = flag_set_t'(5'b11110);
    localparam flag_set_t UPD_CY    = flag_set_t'(5'b00001);
    localparam flag_set_t UPD_NONE  = flag_set_t'(5'b00000);

    function automatic flag_set_t unpack_flags(input logic [7:0] b);
        flag_set_t f;
        f.s  = b[FB_S];
        f.z  = b[FB_Z];
        f.ac = b[FB_AC];
        f.p  = b[FB_P];
        f.cy = b[FB_CY];
        return f;
    endfunction

    function automatic logic [7:0] pack_flags(input flag_set_t f);
        logic [7:0] b;
        b        = '0;
        b[FB_S]  = f.s;
        b[FB_Z]  = f.z;
        b[FB_AC] = f.ac;
        b[FB_P]  = f.p;
        b[FB_CY] = f.cy;
        return b;
    endfunction

    function automatic flag_set_t merge_flags(input flag_set_t old_f,
                                              input flag_set_t new_f,
                                              input flag_set_t upd);
        return flag_set_t'((new_f & upd) | (old_f & ~upd));
    endfunction

endpackage

// File: rtl/alu8_opsel.sv
module alu8_opsel #(
    parameter int DW = 8
) (
    input  logic [1:0]    sel,
    input  logic [DW-1:0] reg_v,
    input  logic [DW-1:0] mem_v,
    input  logic [DW-1:0] imm_v,
    output logic [DW-1:0] opnd
);
    always_comb begin
        case (sel)
            2'b00:   opnd = reg_v;
            2'b01:   opnd = mem_v;
            default: opnd = imm_v;
        endcase
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  op_e           op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [7:0]    flg_in,
    output logic [DW-1:0] res,
    output logic          wr_acc,
    output logic [7:0]    flg_nxt
);
    localparam int HW = DW / 2;

    flag_set_t       cur;
    flag_set_t       calc;
    flag_set_t       upd;
    logic [DW:0]     wide;
    logic [HW:0]     half;
    logic            cin;

    assign cur = unpack_flags(flg_in);
    assign cin = ((op == OP_ADC) || (op == OP_SBB)) ? cur.cy : 1'b0;

    always_comb begin
        wide   = '0;
        half   = '0;
        res    = a;
        wr_acc = 1'b1;
        upd    = UPD_NONE;
        calc   = cur;
        case (op)
            OP_ADD, OP_ADC: begin
                wide    = {1'b0, a} + {1'b0, b} + (DW+1)'(cin);
                half    = {1'b0, a[HW-1:0]} + {1'b0, b[HW-1:0]} + (HW+1)'(cin);
                res     = wide[DW-1:0];
                calc.cy = wide[DW];
                calc.ac = half[HW];
                upd     = UPD_ALL;
            end
            OP_SUB, OP_SBB, OP_CMP: begin
                wide    = {1'b0, a} - {1'b0, b} - (DW+1)'(cin);
                half    = {1'b0, a[HW-1:0]} - {1'b0, b[HW-1:0]} - (HW+1)'(cin);
                res     = wide[DW-1:0];
                calc.cy = wide[DW];
                calc.ac = half[HW];
                wr_acc  = (op != OP_CMP);
                upd     = UPD_ALL;
            end
            OP_INC: begin
                wide    = {1'b0, a} + (DW+1)'(1);
                half    = {1'b0, a[HW-1:0]} + (HW+1)'(1);
                res     = wide[DW-1:0];
                calc.ac = half[HW];
                upd     = UPD_NO_CY;
            end
            OP_DEC: begin
                wide    = {1'b0, a} - (DW+1)'(1);
                half    = {1'b0, a[HW-1:0]} - (HW+1)'(1);
                res     = wide[DW-1:0];
                calc.ac = half[HW];
                upd     = UPD_NO_CY;
            end
            OP_AND, OP_OR, OP_XOR: begin
                res     = (op == OP_AND) ? (a & b) :
                          (op == OP_OR)  ? (a | b) : (a ^ b);
                calc.cy = 1'b0;
                calc.ac = 1'b0;
                upd     = UPD_ALL;
            end
            OP_CPL: begin
                res = ~a;
            end
            OP_RLC: begin
                res     = {a[DW-2:0], a[DW-1]};
                calc.cy = a[DW-1];
                upd     = UPD_CY;
            end
            OP_RRC: begin
                res     = {a[0], a[DW-1:1]};
                calc.cy = a[0];
                upd     = UPD_CY;
            end
            default: begin
                res    = a;
                wr_acc = 1'b0;
            end
        endcase
        calc.s  = res[DW-1];
        calc.z  = (res == '0);
        calc.p  = ~^res;
        flg_nxt = pack_flags(merge_flags(cur, calc, upd));
    end
endmodule

// File: rtl/alu8_flagreg.sv
module alu8_flagreg
    import alu8_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic [7:0] d,
    output logic [7:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (we)
            q <= d;
    end

    // R11
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(q));

    // R10
    unused_bits_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> ((q & ~FLAG_USED) == 8'h00));

    // R11
    flag_load_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> (q == $past(d)));
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [3:0]    op_i,
    input  logic [1:0]    src_sel_i,
    input  logic [DW-1:0] acc_i,
    input  logic [DW-1:0] reg_i,
    input  logic [DW-1:0] mem_i,
    input  logic [DW-1:0] imm_i,
    input  logic          flag_we_i,
    output logic [DW-1:0] result_o,
    output logic          acc_we_o,
    output logic [7:0]    flags_o
);
    logic [DW-1:0] opnd_b;
    logic [7:0]    flg_nxt;
    op_e           op;

    assign op = op_e'(op_i);

    alu8_opsel #(.DW(DW)) u_opsel (
        .sel   (src_sel_i),
        .reg_v (reg_i),
        .mem_v (mem_i),
        .imm_v (imm_i),
        .opnd  (opnd_b)
    );

    alu8_core #(.DW(DW)) u_core (
        .op      (op),
        .a       (acc_i),
        .b       (opnd_b),
        .flg_in  (flags_o),
        .res     (result_o),
        .wr_acc  (acc_we_o),
        .flg_nxt (flg_nxt)
    );

    alu8_flagreg u_flags (
        .clk (clk),
        .rst (rst),
        .we  (flag_we_i),
        .d   (flg_nxt),
        .q   (flags_o)
    );

    // R3
    cmp_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == 4'd9) |-> !acc_we_o);

    // R9
    cpl_keeps_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_we_i && op_i == 4'd10) |=> $stable(flags_o));

    // R7
    logic_clears_cy_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_we_i && (op_i == 4'd6 || op_i == 4'd7 || op_i == 4'd8))
        |=> (flags_o[FB_CY] == 1'b0 && flags_o[FB_AC] == 1'b0));

    // R4
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_we_i && op_i <= 4'd9)
        |=> (flags_o[FB_Z] == ($past(result_o) == '0)));

    // R12
    spare_op_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i >= 4'd13) |-> (!acc_we_o && result_o == acc_i));
endmodule

// File: tb/alu8_flags_tb.sv
module alu8_flags_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] op_i;
    logic [1:0] src_sel_i;
    logic [7:0] acc_i, reg_i, mem_i, imm_i;
    logic       flag_we_i;
    logic [7:0] result_o;
    logic       acc_we_o;
    logic [7:0] flags_o;

    int n_chk  = 0;
    int n_fail = 0;
    int mflags = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    alu8_flags u_dut (
        .clk(clk), .rst(rst), .op_i(op_i), .src_sel_i(src_sel_i),
        .acc_i(acc_i), .reg_i(reg_i), .mem_i(mem_i), .imm_i(imm_i),
        .flag_we_i(flag_we_i), .result_o(result_o), .acc_we_o(acc_we_o),
        .flags_o(flags_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    function automatic int even_ones(input int v);
        int c = 0;
        for (int k = 0; k < 8; k++) c += (v >> k) & 1;
        return ((c % 2) == 0) ? 1 : 0;
    endfunction

    // Behavioural reference; kind: 0 none, 1 all, 2 all but CY, 3 CY only
    task automatic model(input int op, input int a, input int b, input int fl,
                         output int res, output int we, output int nfl);
        int cy, ac, kind, t, c;
        cy = fl & 1; ac = (fl >> 4) & 1; kind = 0; we = 1; res = a;
        c = ((op == 1) || (op == 3)) ? (fl & 1) : 0;
        case (op)
            0, 1: begin t = a + b + c; res = t & 255; cy = (t > 255);
                        ac = (((a & 15) + (b & 15) + c) > 15); kind = 1; end
            2, 3, 9: begin t = a - b - c; res = t & 255; cy = (t < 0);
                        ac = ((a & 15) < ((b & 15) + c)); kind = 1; we = (op != 9); end
            4: begin res = (a + 1) & 255; ac = ((a & 15) == 15); kind = 2; end
            5: begin res = (a - 1) & 255; ac = ((a & 15) == 0); kind = 2; end
            6: begin res = a & b; cy = 0; ac = 0; kind = 1; end
            7: begin res = a | b; cy = 0; ac = 0; kind = 1; end
            8: begin res = a ^ b; cy = 0; ac = 0; kind = 1; end
            10: res = (~a) & 255;
            11: begin res = ((a << 1) | (a >> 7)) & 255; cy = a >> 7; kind = 3; end
            12: begin res = (a >> 1) | ((a & 1) << 7); cy = a & 1; kind = 3; end
            default: begin res = a; we = 0; end
        endcase
        case (kind)
            1, 2: nfl = (((res >> 7) & 1) << 7) | ((res == 0) << 6) | (ac << 4)
                      | (even_ones(res) << 2) | cy;
            3: nfl = (fl & 8'hFE) | cy;
            default: nfl = fl;
        endcase
    endtask

    task automatic step(input string req, input int op, input int sel, input int a,
                        input int r, input int m, input int i, input bit we);
        int b, eres, ewe, efl;
        @(negedge clk);
        op_i = 4'(op); src_sel_i = 2'(sel); acc_i = 8'(a);
        reg_i = 8'(r); mem_i = 8'(m); imm_i = 8'(i); flag_we_i = we;
        b = (sel == 0) ? r : (sel == 1) ? m : i;
        model(op, a, b, mflags, eres, ewe, efl);
        #1;
        check(req, "result", int'(result_o), eres);
        check(req, "acc_we", int'(acc_we_o), ewe);
        @(posedge clk);
        #1;
        if (we) mflags = efl;
        check(req, "flags", int'(flags_o), mflags);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; flag_we_i = 1'b1;
        @(posedge clk); #1;
        @(negedge clk);
        rst = 1'b0;
        mflags = 0;
        check("R11", "reset flags", int'(flags_o), 0);
    endtask

    function automatic string tag_of(input int op);
        case (op)
            0, 1:    return "R2";
            2, 3, 9: return "R3";
            4, 5:    return "R8";
            6, 7, 8: return "R7";
            10, 11, 12: return "R9";
            default: return "R12";
        endcase
    endfunction

    initial begin
        rst = 1'b1; op_i = '0; src_sel_i = '0; acc_i = '0; reg_i = '0;
        mem_i = '0; imm_i = '0; flag_we_i = 1'b0;
        do_reset();
        // R2 R4 R6: wrap to zero, Z P CY set
        step("R2", 0, 0, 8'h80, 8'h80, 0, 0, 1);
        check("R10", "packed Z|P|CY", int'(flags_o), 8'h45);
        step("R2", 1, 2, 8'h10, 0, 0, 8'h01, 1);           // ADC with CY=1
        step("R5", 0, 1, 8'h0F, 0, 8'h01, 0, 1);           // half carry
        step("R3", 2, 0, 8'h10, 8'h20, 0, 0, 1);           // borrow
        step("R3", 3, 0, 8'h50, 8'h10, 0, 0, 1);           // SBB with CY=1
        step("R5", 5, 0, 8'h10, 0, 0, 0, 1);               // DEC nibble borrow
        step("R3", 9, 3, 8'h42, 0, 0, 8'h42, 1);           // CMP equal
        step("R4", 0, 0, 8'h70, 8'h10, 0, 0, 1);           // sign
        step("R6", 8, 0, 8'h03, 8'h04, 0, 0, 1);           // odd ones
        step("R2", 0, 0, 8'hFF, 8'h01, 0, 0, 1);           // set CY
        step("R8", 4, 0, 8'hFF, 0, 0, 0, 1);               // INC keeps CY
        step("R7", 6, 0, 8'hF0, 8'h3C, 0, 0, 1);           // AND clears CY
        step("R2", 0, 0, 8'hFF, 8'h01, 0, 0, 1);
        step("R9", 10, 0, 8'h5A, 0, 0, 0, 1);              // CPL keeps flags
        step("R9", 11, 0, 8'h81, 0, 0, 0, 1);              // RLC
        step("R9", 12, 0, 8'h02, 0, 0, 0, 1);              // RRC
        step("R12", 14, 0, 8'h37, 8'h11, 0, 0, 1);
        step("R11", 0, 0, 8'h00, 8'h00, 0, 0, 0);          // load disabled
        step("R1", 0, 1, 8'h01, 8'h10, 8'h20, 8'h40, 1);
        step("R1", 0, 2, 8'h01, 8'h10, 8'h20, 8'h40, 1);
        step("R1", 0, 3, 8'h01, 8'h10, 8'h20, 8'h40, 1);
        step("R1", 0, 0, 8'h01, 8'h10, 8'h20, 8'h40, 1);
        do_reset();
        begin
            logic [31:0] st = 32'h1234_5678;
            for (int n = 0; n < 4000; n++) begin
                int op;
                st ^= st << 13; st ^= st >> 17; st ^= st << 5;
                op = int'(st[3:0]);
                step(tag_of(op), op, int'(st[5:4]), int'(st[15:8]), int'(st[23:16]),
                     int'(st[31:24]), int'(st[7:0] ^ st[31:24]), st[6] | st[9]);
            end
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual still running, expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule